// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Character Refresher

This block refreshes an eight-position LED character display in which every position is a grid of five columns by seven rows. It works through the positions in turn. Each position gets a fixed slot of scan-clock cycles, and during that slot the block raises a one-hot position select and presents all 35 dot drive bits of the glyph for that position. Glyph patterns come from one of two sources. The first is a fixed font that the block computes for character codes 0 to 127. The second is a small writable pattern store that holds sixteen user glyphs.

The host writes through a synchronous port. This port loads character codes, per-position flash flags and user glyph columns. A separate clear input empties the character buffer. The display can dim on a slow blink phase in two ways: only the positions that carry a flash flag, or the whole display. A self-test input lights every dot. A clock-select input chooses the scan clock. When it is high, the block runs from its own oscillator and exports that clock so that other units can use it. When it is low, the block runs as a slave on the clock it receives.

Top module: `dotmatrix_refresh`

## Requirements
- R1: The position select `digit_sel` is one-hot. Bit 0 is active after reset. Each position holds for `SLOT_CYCLES` scan-clock cycles (default 28), and the select then moves to the next bit, wrapping from bit 7 back to bit 0.
- R2: In the first cycle of every slot, `dot_drive` is all zero, whatever the buffer, flash, blink or self-test state.
- R3: A code with bit 7 clear selects the fixed font. Column k (0..4) occupies `dot_drive[7k+6:7k]`, with bit 7k being row 0. Its value is the 7-bit code rotated left by k places, XORed with k. Code 0 is the blank glyph, with all columns zero.
- R4: A code with bit 7 set selects user glyph `code[3:0]`. Its columns come from the user store. A write with `wr_kind`=2 stores `wr_data[6:0]` as column `wr_addr[2:0]` of glyph `wr_addr[6:3]`. A column index of 5 or more is ignored.
- R5: The blink phase starts lit. It inverts every `BLINK_HALF` scan-clock cycles. In the dark phase, a position that carries a flash flag shows all-zero dots. When `blink_all` is high, every position shows all-zero dots in the dark phase.
- R6: A `clear` pulse sets every character code to 0 and every flash flag to 0. If a write arrives in the same cycle as a clear, the clear wins.
- R7: While `self_test` is high, every dot is lit outside the first cycle of a slot. This holds whatever the codes and the blink phase are.
- R8: When `clk_sel`=1, the scan runs on `osc_clk`, `clk_out` follows `osc_clk` and `clk_out_en` is 1. When `clk_sel`=0, the scan runs only on `ext_clk`, `clk_out` is 0 and `clk_out_en` is 0.
- R9: Reset, an asynchronous active-low input, restarts the scan at position 0 slot cycle 0 and restarts the blink phase lit with a full half-period. It also empties the buffer, the flash flags and the user store.
- R10: A write with `wr_kind`=0 stores `wr_data` as the code of position `wr_addr[2:0]`. A write with `wr_kind`=1 stores `wr_data[0]` as the flash flag of that position. The glyph and flash flag shown in a slot are captured at the end of the previous slot, so a write only becomes visible at the next scan of that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Local oscillator clock |
| ext_clk | input | 1 | Clock received from a master unit |
| clk_sel | input | 1 | 1: master on osc_clk, 0: slave on ext_clk |
| clk_out | output | 1 | Exported scan clock (valid when clk_out_en) |
| clk_out_en | output | 1 | Drive enable for the exported clock |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 code, 1 flash flag, 2 user glyph column, 3 none |
| wr_addr | input | 7 | Position index or {glyph, column} |
| wr_data | input | 8 | Write data |
| clear | input | 1 | Empty the buffer and flash flags |
| blink_all | input | 1 | Blink the whole display |
| self_test | input | 1 | Light all dots |
| digit_sel | output | 8 | One-hot position select |
| dot_drive | output | 35 | Dot pattern, column-major, 7 bits per column |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear and a code write. The bench provokes this directly by raising `clear` together with a write to one position. It then judges the outcome by waiting for that position's next slot and expecting a blank glyph. The second pair is a host write and the slot-end capture for the same position. The bench writes to the position that is on display in the middle of its slot, expects the old pattern to stay until the slot ends, and expects the new one on the following scan. Random stimulus also lands writes, clears and mode changes on slot boundaries and blink-phase edges, and a cycle-level model in the bench judges every output.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int unsigned GLYPH_COLS = 5;
  localparam int unsigned GLYPH_ROWS = 7;
  localparam int unsigned GLYPH_BITS = GLYPH_COLS * GLYPH_ROWS;
  localparam int unsigned UDC_SLOTS  = 16;
  localparam int unsigned WADDR_W    = 7;

  typedef logic [GLYPH_ROWS-1:0] dm_col_t;
  typedef logic [GLYPH_BITS-1:0] dm_glyph_t;

  typedef enum logic [1:0] {
    WR_CHAR  = 2'd0,
    WR_FLASH = 2'd1,
    WR_UDC   = 2'd2,
    WR_NONE  = 2'd3
  } dm_wr_kind_e;

  // Fixed font column: code rotated left by col, XOR col; code 0 is blank.
  function automatic dm_col_t rom_column(input logic [6:0] code, input logic [2:0] col);
    logic [13:0] dbl;
    dm_col_t     rot;
    if (code == 7'd0) return '0;
    dbl = {code, code};
    rot = dm_col_t'(dbl >> (7 - int'(col)));
    return rot ^ dm_col_t'(col);
  endfunction
endpackage

// File: rtl/dm_clk_sel.sv
module dm_clk_sel (
  input  logic clk_sel,
  input  logic osc_clk,
  input  logic ext_clk,
  output logic scan_clk,
  output logic clk_out,
  output logic clk_out_en
);
  always_comb begin
    scan_clk   = clk_sel ? osc_clk : ext_clk;
    clk_out    = clk_sel & osc_clk;
    clk_out_en = clk_sel;
  end
endmodule

// File: rtl/dm_scan_timer.sv
module dm_scan_timer #(
  parameter int unsigned NUM_DIGITS  = 8,
  parameter int unsigned SLOT_CYCLES = 28,
  parameter int unsigned BLINK_HALF  = 14336
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [$clog2(SLOT_CYCLES)-1:0] slot_pos,
  output logic [$clog2(NUM_DIGITS)-1:0]  next_digit,
  output logic                          slot_end,
  output logic                          blink_on,
  output logic [NUM_DIGITS-1:0]         digit_sel
);
  localparam int unsigned POS_W = $clog2(SLOT_CYCLES);
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS);
  localparam int unsigned BLK_W = $clog2(BLINK_HALF);

  logic [DIG_W-1:0] digit;
  logic [BLK_W-1:0] blink_cnt;
  logic             blink_edge;

  assign slot_end   = (slot_pos == POS_W'(SLOT_CYCLES - 1));
  assign next_digit = (digit == DIG_W'(NUM_DIGITS - 1)) ? '0 : digit + DIG_W'(1);
  assign blink_edge = (blink_cnt == BLK_W'(BLINK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_pos  <= '0;
      digit     <= '0;
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else begin
      slot_pos  <= slot_end ? '0 : slot_pos + POS_W'(1);
      if (slot_end) digit <= next_digit;
      blink_cnt <= blink_edge ? '0 : blink_cnt + BLK_W'(1);
      if (blink_edge) blink_on <= ~blink_on;
    end
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_sel
    assign digit_sel[d] = (digit == DIG_W'(d));
  end

  // R1
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> digit == $past(next_digit));
  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(digit));
  // R5
  blink_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blink_edge |=> blink_on != $past(blink_on));
endmodule

// File: rtl/dm_glyph_store.sv
module dm_glyph_store
  import dm_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_kind,
  input  logic [WADDR_W-1:0]            wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic                          clear,
  input  logic                          load,
  input  logic [$clog2(NUM_DIGITS)-1:0] load_digit,
  output dm_glyph_t                     cur_glyph,
  output logic                          cur_flash
);
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS);

  logic [7:0]              code_q  [NUM_DIGITS];
  logic [NUM_DIGITS-1:0]   flash_q;
  dm_col_t                 udc_q   [UDC_SLOTS][GLYPH_COLS];
  logic [NUM_DIGITS*8-1:0] code_flat;
  logic [7:0]              sel_code;
  dm_glyph_t               next_glyph;
  logic [2:0]              wr_col;

  assign wr_col = wr_addr[2:0];

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_flat
    assign code_flat[d*8 +: 8] = code_q[d];
  end

  always_comb begin
    sel_code = code_q[load_digit];
    for (int k = 0; k < GLYPH_COLS; k++) begin
      next_glyph[k*GLYPH_ROWS +: GLYPH_ROWS] = sel_code[7] ? udc_q[sel_code[3:0]][k]
                                                           : rom_column(sel_code[6:0], 3'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DIGITS; d++) code_q[d] <= '0;
      for (int g = 0; g < UDC_SLOTS; g++)
        for (int k = 0; k < GLYPH_COLS; k++) udc_q[g][k] <= '0;
      flash_q   <= '0;
      cur_glyph <= '0;
      cur_flash <= 1'b0;
    end else begin
      if (load) begin
        cur_glyph <= next_glyph;
        cur_flash <= flash_q[load_digit];
      end
      if (clear) begin
        for (int d = 0; d < NUM_DIGITS; d++) code_q[d] <= '0;
        flash_q <= '0;
      end else if (wr_en) begin
        case (dm_wr_kind_e'(wr_kind))
          WR_CHAR:  code_q[wr_addr[DIG_W-1:0]]  <= wr_data;
          WR_FLASH: flash_q[wr_addr[DIG_W-1:0]] <= wr_data[0];
          WR_UDC:   if (wr_col < 3'(GLYPH_COLS)) udc_q[wr_addr[6:3]][wr_col] <= wr_data[6:0];
          default: ;
        endcase
      end
    end
  end

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (code_flat == '0) && (flash_q == '0));
endmodule

// File: rtl/dotmatrix_refresh.sv
module dotmatrix_refresh
  import dm_pkg::*;
#(
  parameter int unsigned NUM_DIGITS  = 8,
  parameter int unsigned SLOT_CYCLES = 28,
  parameter int unsigned BLINK_HALF  = 14336
) (
  input  logic                  rst_n,
  input  logic                  osc_clk,
  input  logic                  ext_clk,
  input  logic                  clk_sel,
  output logic                  clk_out,
  output logic                  clk_out_en,
  input  logic                  wr_en,
  input  logic [1:0]            wr_kind,
  input  logic [WADDR_W-1:0]    wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  clear,
  input  logic                  blink_all,
  input  logic                  self_test,
  output logic [NUM_DIGITS-1:0] digit_sel,
  output logic [GLYPH_BITS-1:0] dot_drive
);
  localparam int unsigned POS_W = $clog2(SLOT_CYCLES);
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS);

  logic             scan_clk;
  logic [POS_W-1:0] slot_pos;
  logic [DIG_W-1:0] next_digit;
  logic             slot_end;
  logic             blink_on;
  dm_glyph_t        cur_glyph;
  logic             cur_flash;
  logic             slot_blank;
  logic             blink_dark;

  dm_clk_sel u_clk (
    .clk_sel    (clk_sel),
    .osc_clk    (osc_clk),
    .ext_clk    (ext_clk),
    .scan_clk   (scan_clk),
    .clk_out    (clk_out),
    .clk_out_en (clk_out_en)
  );

  dm_scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .SLOT_CYCLES (SLOT_CYCLES),
    .BLINK_HALF  (BLINK_HALF)
  ) u_timer (
    .clk        (scan_clk),
    .rst_n      (rst_n),
    .slot_pos   (slot_pos),
    .next_digit (next_digit),
    .slot_end   (slot_end),
    .blink_on   (blink_on),
    .digit_sel  (digit_sel)
  );

  dm_glyph_store #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_store (
    .clk        (scan_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_kind    (wr_kind),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .clear      (clear),
    .load       (slot_end),
    .load_digit (next_digit),
    .cur_glyph  (cur_glyph),
    .cur_flash  (cur_flash)
  );

  assign slot_blank = (slot_pos == '0);
  assign blink_dark = !blink_on && (blink_all || cur_flash);

  always_comb begin
    if (slot_blank)      dot_drive = '0;
    else if (self_test)  dot_drive = '1;
    else if (blink_dark) dot_drive = '0;
    else                 dot_drive = cur_glyph;
  end

  // R2
  slot_blank_chk: assert property (@(posedge scan_clk) disable iff (!rst_n)
    slot_end |=> dot_drive == '0);
  // R5
  full_blink_chk: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (!blink_on && blink_all && !self_test) |-> dot_drive == '0);
  // R7
  self_test_chk: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (self_test && !slot_blank) |-> dot_drive == '1);
endmodule

// File: tb/dotmatrix_refresh_tb.sv
module dotmatrix_refresh_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;
  localparam int SLOT = 28;
  localparam int BH = 40;

  logic rst_n = 1'b0, osc_clk = 1'b0, ext_clk = 1'b0, clk_sel = 1'b1;
  logic clk_out, clk_out_en;
  logic wr_en = 1'b0, clear = 1'b0, blink_all = 1'b0, self_test = 1'b0;
  logic [1:0] wr_kind = 2'd3;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [ND-1:0] digit_sel;
  logic [34:0] dot_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  dotmatrix_refresh #(.NUM_DIGITS(ND), .SLOT_CYCLES(SLOT), .BLINK_HALF(BH)) u_dut (
    .rst_n(rst_n), .osc_clk(osc_clk), .ext_clk(ext_clk), .clk_sel(clk_sel),
    .clk_out(clk_out), .clk_out_en(clk_out_en), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_addr(wr_addr), .wr_data(wr_data), .clear(clear), .blink_all(blink_all),
    .self_test(self_test), .digit_sel(digit_sel), .dot_drive(dot_drive));

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  wire tb_sclk = clk_sel ? osc_clk : ext_clk;

  // Bench model of the requirements
  int m_pos, m_dig, m_bcnt, m_since;
  bit m_bon, m_gflash;
  logic [7:0] m_code [ND];
  bit [ND-1:0] m_flash;
  logic [6:0] m_udc [16][5];
  logic [34:0] m_glyph;
  logic [7:0] m_gcode;

  function automatic logic [6:0] font_col(logic [6:0] c, int k);
    logic [6:0] r;
    if (c == 0) return 7'd0;
    r = 7'((c << k) | (c >> (7 - k)));
    return r ^ 7'(k);
  endfunction

  function automatic logic [34:0] glyph_of(logic [7:0] c);
    logic [34:0] g;
    for (int k = 0; k < 5; k++)
      g[k*7 +: 7] = c[7] ? m_udc[c[3:0]][k] : font_col(c[6:0], k);
    return g;
  endfunction

  always @(posedge tb_sclk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_dig = 0; m_bcnt = 0; m_bon = 1; m_since = 0;
      for (int d = 0; d < ND; d++) m_code[d] = 8'd0;
      for (int g = 0; g < 16; g++) for (int k = 0; k < 5; k++) m_udc[g][k] = 7'd0;
      m_flash = '0; m_glyph = '0; m_gflash = 0; m_gcode = 8'd0;
    end else begin
      if (m_pos == SLOT-1) begin
        m_gcode = m_code[(m_dig+1)%ND];
        m_glyph = glyph_of(m_gcode);
        m_gflash = m_flash[(m_dig+1)%ND];
      end
      if (clear) begin
        for (int d = 0; d < ND; d++) m_code[d] = 8'd0;
        m_flash = '0;
      end else if (wr_en) begin
        if (wr_kind == 2'd0) m_code[wr_addr[2:0]] = wr_data;
        else if (wr_kind == 2'd1) m_flash[wr_addr[2:0]] = wr_data[0];
        else if (wr_kind == 2'd2 && wr_addr[2:0] < 5) m_udc[wr_addr[6:3]][wr_addr[2:0]] = wr_data[6:0];
      end
      if (m_pos == SLOT-1) begin m_pos = 0; m_dig = (m_dig+1)%ND; end
      else m_pos = m_pos + 1;
      if (m_bcnt == BH-1) begin m_bcnt = 0; m_bon = !m_bon; end
      else m_bcnt = m_bcnt + 1;
      m_since = m_since + 1;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [34:0] e;
    string tag;
    check(digit_sel == (ND'(1) << m_dig), "R1 digit select", 64'(digit_sel), 64'(ND'(1) << m_dig));
    if (m_pos == 0) begin e = '0; tag = "R2 slot blank"; end
    else if (self_test) begin e = '1; tag = "R7 self test"; end
    else if (!m_bon && (blink_all || m_gflash)) begin
      e = '0; tag = (m_since < 2*BH) ? "R9 blink restart" : "R5 blink dark";
    end else begin e = m_glyph; tag = m_gcode[7] ? "R4 user glyph" : "R3 font glyph"; end
    check(dot_drive == e, tag, 64'(dot_drive), 64'(e));
    check(clk_out_en == clk_sel, "R8 clock enable", 64'(clk_out_en), 64'(clk_sel));
  endtask

  task automatic idle_inputs();
    wr_en = 0; clear = 0; wr_kind = 2'd3;
  endtask

  task automatic write(int kind, int addr, int data);
    wr_en = 1; wr_kind = 2'(kind); wr_addr = 7'(addr); wr_data = 8'(data);
  endtask

  task automatic step();
    @(negedge osc_clk);
    check_outputs();
    idle_inputs();
  endtask

  initial begin
    int unsigned seed;
    logic [34:0] held;
    logic [ND-1:0] sel_held;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    #(CLK_PERIOD*2 + 1);
    // R9 reset state
    check(digit_sel == 8'h01, "R9 reset select", 64'(digit_sel), 64'h01);
    check(dot_drive == '0, "R9 reset dots", 64'(dot_drive), 64'h0);
    @(negedge osc_clk); rst_n = 1;

    // Load a font code and a user glyph
    for (int k = 0; k < 5; k++) begin
      step(); write(2, (3 << 3) | k, 7'h40 >> k | 7'h01);
    end
    step(); write(2, (3 << 3) | 6, 8'h7F);  // column 6 ignored (R4)
    step(); write(0, 0, 8'h41);
    step(); write(0, 1, 8'h83);
    step(); write(0, 2, 8'h11);
    step(); write(1, 1, 1);
    for (int i = 0; i < 3*ND*SLOT; i++) step();

    // R10: write to the position on display mid-slot
    while (!(m_dig == 2 && m_pos == 10)) step();
    held = dot_drive;
    write(0, 2, 8'h22);
    for (int i = 0; i < 10; i++) begin
      step();
      check(dot_drive == held, "R10 hold until next scan", 64'(dot_drive), 64'(held));
    end
    while (!(m_dig == 2 && m_pos == 5)) step();
    check(dot_drive == glyph_of(8'h22), "R10 new glyph", 64'(dot_drive), 64'(glyph_of(8'h22)));

    // R6: clear colliding with a write
    step(); write(0, 4, 8'h55); clear = 1;
    step();
    repeat (ND*SLOT) step();
    while (!(m_dig == 4 && m_pos == 5)) step();
    check(dot_drive == '0, "R6 clear beats write", 64'(dot_drive), 64'h0);

    // R8: slave mode frozen without ext_clk
    step(); clk_sel = 0;
    sel_held = digit_sel; held = dot_drive;
    for (int i = 0; i < 40; i++) begin
      step();
      check(digit_sel == sel_held && dot_drive == held, "R8 frozen", 64'(digit_sel), 64'(sel_held));
      #(CLK_PERIOD/2 - 1);
      check(clk_out == 1'b0, "R8 no export", 64'(clk_out), 64'h0);
    end
    for (int i = 0; i < 3*SLOT; i++) begin
      #(CLK_PERIOD/4) ext_clk = 1;
      #(CLK_PERIOD/4) ext_clk = 0;
      #1 check_outputs();
    end
    @(negedge osc_clk); clk_sel = 1;
    @(posedge osc_clk); #1;
    check(clk_out == 1'b1, "R8 export", 64'(clk_out), 64'h1);

    // Random phase with a mid-run reset
    for (int i = 0; i < 6000; i++) begin
      step();
      if (i == 3000) begin
        rst_n = 0; #1;
        check(digit_sel == 8'h01 && dot_drive == '0, "R9 async reset", 64'(digit_sel), 64'h01);
        @(negedge osc_clk); rst_n = 1;
        for (int d = 0; d < ND; d++) begin step(); write(0, d, $urandom); end
        step(); write(1, 3, 1);
      end else begin
        int r = int'($urandom % 100);
        if (r < 30) write(int'($urandom % 3), int'($urandom), int'($urandom));
        else if (r == 30) clear = 1;
        else if (r == 31 && ($urandom % 4) == 0) blink_all = !blink_all;
        else if (r == 32 && ($urandom % 6) == 0) self_test = !self_test;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule